// File: doc/BRIEF.md
# I2C Slave Address and Status Monitor

This block holds the slave-side status logic of an I2C controller. It watches the synchronized SCL and SDA levels together with start and stop strobes from a bus-condition detector. After every start condition it shifts in the first byte, most significant bit first. It then decides whether the controller has been addressed. The byte can address it in three ways: its 7-bit address matches the programmable own address, the byte is the all-zero general call, or address recognition is switched off so that any first word counts.

Three status results go to software. The address-match flag stays set until the data buffer is read or written. The general-call flag stays set until the bus shows another start or stop. The last-received-bit flag holds the SDA level seen at the latest SCL rising edge, so after the ninth clock it holds the acknowledge. A one-cycle strobe marks the ninth SCL rising edge of an addressed frame, which tells software that the stored acknowledge can be read. Driving the acknowledge and moving data to the CPU are handled elsewhere.

Top module: `i2c_slave_addr_monitor`

## Requirements
- R1: With slave_mode=1 and addr_rec_off=0, addr_match becomes 1 when the first byte after a start has bits [7:1] (the first seven bits shifted in, MSB first) equal to own_addr. Bit [0] is the read/write direction and plays no part in the match.
- R2: With slave_mode=1 and addr_rec_off=0, a first byte of 8'h00 (general call) sets addr_match, whatever the value of own_addr.
- R3: With slave_mode=1 and addr_rec_off=1, addr_match becomes 1 once any first byte after a start has been received, whatever the value of own_addr.
- R4: A one-cycle pulse on dbuf_rd or dbuf_wr clears addr_match.
- R5: gen_call becomes 1 only when slave_mode=1 and the first byte after a start is 8'h00. An all-zero byte later in the frame does not set it. With slave_mode=0, neither gen_call nor addr_match is set.
- R6: A pulse on start_det or stop_det clears gen_call.
- R7: At every SCL rising edge, last_bit takes the SDA level. After the ninth edge of a byte it therefore holds the acknowledge bit.
- R8: ack_irq pulses high for exactly one clock after the ninth SCL rising edge of a byte that set addr_match. It pulses once per addressed frame.
- R9: A start or stop strobe resets the bit position. A repeated start in the middle of a byte therefore begins a fresh address capture.
- R10: After reset, addr_match, gen_call, last_bit and ack_irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Synchronized SCL level |
| sda | input | 1 | Synchronized SDA level |
| start_det | input | 1 | One-cycle strobe: start (or repeated start) seen |
| stop_det | input | 1 | One-cycle strobe: stop seen |
| slave_mode | input | 1 | 1 when the controller acts as a slave |
| addr_rec_off | input | 1 | 1 switches address recognition off (free-data mode) |
| own_addr | input | ADDR_W | Programmed own slave address |
| dbuf_rd | input | 1 | Strobe: data buffer read by software |
| dbuf_wr | input | 1 | Strobe: data buffer written by software |
| addr_match | output | 1 | Address-match flag |
| gen_call | output | 1 | General-call flag |
| last_bit | output | 1 | Last SDA bit sampled on an SCL rise |
| ack_irq | output | 1 | One-cycle strobe after the ninth clock of an addressed frame |

## Verification
The SCL rise is seen at the first clock edge that samples SCL high. last_bit updates on that same edge. The byte-complete event is registered on that edge, so addr_match and gen_call change one edge later, and ack_irq rises one edge after the ninth rise. A flag clear from a buffer strobe or a bus strobe shows one edge after the strobe. The bench changes SCL at falling clock edges and holds each level for at least three edges before it samples outputs at a falling edge. It checks strobe clears two falling edges after the pulse. ack_irq is counted on every rising edge, so both a missing pulse and a doubled pulse are caught.

// File: rtl/i2c_mon_pkg.sv
// Package: shared constants and helpers for the I2C slave address monitor.
// Assumes a 7-bit address plus one direction bit per address byte.
package i2c_mon_pkg;
    localparam int DEF_ADDR_W = 7;

    // True when a received byte is the general-call code (all zeros)
    function automatic logic is_general_call(input logic [DEF_ADDR_W:0] b);
        return (b == '0);
    endfunction
endpackage

// File: rtl/i2c_mon_capture.sv
// Module: i2c_mon_capture
// Finds SCL rising edges, counts bit positions inside a byte and shifts the
// data bits in MSB first. It flags when a byte is complete and whether that
// byte was the first one after a start. It also stores the last SDA bit
// sampled at an SCL rise.
// Assumes scl/sda are already synchronized, and that start/stop strobes are
// one-cycle pulses from an external bus-condition detector.
module i2c_mon_capture #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              last_bit,
    output logic              byte_done,
    output logic              ninth_done,
    output logic              byte_first,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(BYTE_W);

    logic              scl_q;
    logic              scl_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              on_bus;
    logic              first_q;

    // Edge history tracks the line in and out of reset
    always_ff @(posedge clk) begin
        scl_q <= scl;
    end

    assign scl_rise = scl & ~scl_q;

    // Bit position, shift register and byte-complete events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            on_bus     <= 1'b0;
            first_q    <= 1'b0;
            byte_done  <= 1'b0;
            ninth_done <= 1'b0;
            byte_first <= 1'b0;
        end else begin
            byte_done  <= 1'b0;
            ninth_done <= 1'b0;
            if (start_det) begin
                bit_cnt <= '0;
                on_bus  <= 1'b1;
                first_q <= 1'b1;
            end else if (stop_det) begin
                bit_cnt <= '0;
                on_bus  <= 1'b0;
                first_q <= 1'b0;
            end else if (scl_rise && on_bus) begin
                if (bit_cnt == ACK_POS) begin
                    bit_cnt    <= '0;
                    ninth_done <= 1'b1;
                    first_q    <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shreg   <= {shreg[BYTE_W-2:0], sda};
                    if (bit_cnt == LAST_DATA) begin
                        byte_done  <= 1'b1;
                        byte_first <= first_q;
                    end
                end
            end
        end
    end

    // Last received bit: SDA at every SCL rise
    always_ff @(posedge clk) begin
        if (!rst_n) last_bit <= 1'b0;
        else if (scl_rise) last_bit <= sda;
    end

    assign byte_val = shreg;

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= ACK_POS);
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> (bit_cnt == '0));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ninth_done |=> !ninth_done);
endmodule

// File: rtl/i2c_mon_flags.sv
// Module: i2c_mon_flags
// Holds the address-match flag, the general-call flag and the acknowledge
// strobe. It acts on the first byte after a start only.
// Assumes byte_val stays stable in the cycle that byte_done is high.
module i2c_mon_flags #(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slave_mode,
    input  logic            addr_rec_off,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic            byte_done,
    input  logic            ninth_done,
    input  logic            byte_first,
    input  logic [ADDR_W:0] byte_val,
    input  logic            bus_cond,
    input  logic            dbuf_access,
    output logic            addr_match,
    output logic            gen_call,
    output logic            ack_irq
);
    logic first_ev;
    logic gc_code;
    logic own_hit;
    logic match_ev;
    logic irq_pend;

    // Classify the first byte after a start
    always_comb begin
        first_ev = byte_done & byte_first & slave_mode;
        gc_code  = (byte_val == '0);
        own_hit  = (byte_val[ADDR_W:1] == own_addr);
        match_ev = first_ev & (addr_rec_off | own_hit | gc_code);
    end

    // Address-match flag: set by a matched first byte, cleared by buffer access
    always_ff @(posedge clk) begin
        if (!rst_n) addr_match <= 1'b0;
        else if (match_ev) addr_match <= 1'b1;
        else if (dbuf_access) addr_match <= 1'b0;
    end

    // General-call flag: set by an all-zero first byte, cleared by start/stop
    always_ff @(posedge clk) begin
        if (!rst_n) gen_call <= 1'b0;
        else if (bus_cond) gen_call <= 1'b0;
        else if (first_ev && gc_code) gen_call <= 1'b1;
    end

    // Acknowledge strobe after the ninth clock of a matched byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
            ack_irq  <= 1'b0;
        end else begin
            ack_irq <= ninth_done & irq_pend & ~bus_cond;
            if (bus_cond) irq_pend <= 1'b0;
            else if (match_ev) irq_pend <= 1'b1;
            else if (ninth_done) irq_pend <= 1'b0;
        end
    end

    assert_match_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_access && !byte_done) |=> !addr_match);
    assert_match_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_match) |-> $past(byte_done && byte_first && slave_mode));
    assert_gc_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_call) |-> $past(byte_done && byte_first && slave_mode));
    assert_gc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cond |=> !gen_call);
    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_irq |=> !ack_irq);
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_irq |-> $past(ninth_done));
endmodule

// File: rtl/i2c_slave_addr_monitor.sv
// Module: i2c_slave_addr_monitor (top)
// Slave address recognition and status flags for an I2C controller.
// Ties the bit capture to the flag logic.
// Assumes synchronized bus levels and one-cycle start/stop/buffer strobes.
module i2c_slave_addr_monitor #(
    parameter int ADDR_W = i2c_mon_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              slave_mode,
    input  logic              addr_rec_off,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              dbuf_rd,
    input  logic              dbuf_wr,
    output logic              addr_match,
    output logic              gen_call,
    output logic              last_bit,
    output logic              ack_irq
);
    localparam int BYTE_W = ADDR_W + 1;

    logic              byte_done;
    logic              ninth_done;
    logic              byte_first;
    logic [BYTE_W-1:0] byte_val;
    logic              bus_cond;
    logic              dbuf_access;

    assign bus_cond    = start_det | stop_det;
    assign dbuf_access = dbuf_rd | dbuf_wr;

    i2c_mon_capture #(.BYTE_W(BYTE_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (scl),
        .sda        (sda),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .last_bit   (last_bit),
        .byte_done  (byte_done),
        .ninth_done (ninth_done),
        .byte_first (byte_first),
        .byte_val   (byte_val)
    );

    i2c_mon_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .slave_mode   (slave_mode),
        .addr_rec_off (addr_rec_off),
        .own_addr     (own_addr),
        .byte_done    (byte_done),
        .ninth_done   (ninth_done),
        .byte_first   (byte_first),
        .byte_val     (byte_val),
        .bus_cond     (bus_cond),
        .dbuf_access  (dbuf_access),
        .addr_match   (addr_match),
        .gen_call     (gen_call),
        .ack_irq      (ack_irq)
    );

    assert_last_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl) |=> (last_bit == $past(sda)));
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> !(addr_match || gen_call || ack_irq));
endmodule

// File: tb/i2c_slave_addr_monitor_bench.sv
module i2c_slave_addr_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       start_det = 1'b0, stop_det = 1'b0;
    logic       slave_mode = 1'b1, addr_rec_off = 1'b0;
    logic [6:0] own_addr = 7'h2A;
    logic       dbuf_rd = 1'b0, dbuf_wr = 1'b0;
    logic       addr_match, gen_call, last_bit, ack_irq;
    int n_chk = 0, n_fail = 0, irq_cnt = 0;

    always #4 clk = ~clk;

    i2c_slave_addr_monitor u_i2c_slave_addr_monitor (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
        .start_det(start_det), .stop_det(stop_det),
        .slave_mode(slave_mode), .addr_rec_off(addr_rec_off),
        .own_addr(own_addr), .dbuf_rd(dbuf_rd), .dbuf_wr(dbuf_wr),
        .addr_match(addr_match), .gen_call(gen_call),
        .last_bit(last_bit), .ack_irq(ack_irq)
    );

    always @(posedge clk) if (rst_n && ack_irq) irq_cnt <= irq_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic bit exp_match(input logic [7:0] v, input logic [6:0] own,
                                     input bit off, input bit slv);
        return slv && (off || v[7:1] == own || v == 8'h00);
    endfunction

    function automatic bit exp_gc(input logic [7:0] v, input bit slv);
        return slv && (v == 8'h00);
    endfunction

    task automatic pulse_bus(input bit is_stop);
        @(negedge clk);
        if (is_stop) stop_det = 1'b1; else start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0; stop_det = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_buf(input bit wr);
        @(negedge clk);
        if (wr) dbuf_wr = 1'b1; else dbuf_rd = 1'b1;
        @(negedge clk);
        dbuf_wr = 1'b0; dbuf_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        scl = 1'b0; sda = b;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(ack);
    endtask

    // One full addressed frame compared with the bench model
    task automatic frame(input logic [7:0] v, input bit off, input bit slv, input logic ack);
        int irq0;
        bit em;
        addr_rec_off = off; slave_mode = slv;
        pulse_buf($urandom % 2);
        check(addr_match == 1'b0, "R4 match cleared by buffer access", addr_match, 0);
        pulse_bus(1'b0);
        check(gen_call == 1'b0, "R6 gen_call cleared by start", gen_call, 0);
        irq0 = irq_cnt;
        send_byte(v, ack);
        em = exp_match(v, own_addr, off, slv);
        check(addr_match == em, off ? "R3 free-mode match" : (v == 0 ? "R2 general call match" : "R1 own address match"),
              addr_match, em);
        check(gen_call == exp_gc(v, slv), "R5 general call flag", gen_call, exp_gc(v, slv));
        check(last_bit == ack, "R7 last bit holds acknowledge", last_bit, ack);
        check(irq_cnt - irq0 == int'(em), "R8 ack strobe count", irq_cnt - irq0, int'(em));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0000_51A7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!addr_match && !gen_call && !last_bit && !ack_irq, "R10 reset state",
              {addr_match, gen_call, last_bit, ack_irq}, 0);

        // Directed: own address with read bit, NACK
        frame(8'h55, 1'b0, 1'b1, 1'b1);
        // A later all-zero byte in the same frame must not set gen_call (R5)
        send_byte(8'h00, 1'b0);
        check(gen_call == 1'b0, "R5 later zero byte ignored", gen_call, 0);
        check(addr_match == 1'b1, "R1 match held until buffer access", addr_match, 1);
        pulse_buf(1'b1);
        check(addr_match == 1'b0, "R4 cleared by buffer write", addr_match, 0);

        // Directed: repeated start mid-byte restarts capture (R9)
        pulse_bus(1'b0);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        pulse_bus(1'b0);
        send_byte(8'h00, 1'b0);
        check(gen_call == 1'b1, "R9 capture restarted by repeated start", gen_call, 1);
        check(addr_match == 1'b1, "R9 match after restart", addr_match, 1);
        pulse_bus(1'b1);
        check(gen_call == 1'b0, "R6 gen_call cleared by stop", gen_call, 0);

        // Directed: not in slave mode, zero byte, and free mode with a mismatch
        frame(8'h00, 1'b0, 1'b0, 1'b0);
        frame(8'hF0, 1'b1, 1'b1, 1'b0);
        frame(8'h54, 1'b0, 1'b1, 1'b0);
        frame(8'h12, 1'b0, 1'b1, 1'b1);

        // Random frames
        for (int k = 0; k < 60; k++) begin
            logic [7:0] v;
            int sel;
            own_addr = 7'($urandom);
            sel = $urandom % 4;
            if (sel == 0) v = {own_addr, 1'($urandom)};
            else if (sel == 1) v = 8'h00;
            else v = 8'($urandom);
            frame(v, ($urandom % 4) == 0, ($urandom % 5) != 0, 1'($urandom));
            if ($urandom % 2) begin
                pulse_bus(1'b1);
                check(gen_call == 1'b0, "R6 gen_call cleared by stop", gen_call, 0);
            end
        end
        finish_run();
    end
endmodule